// File: doc/BRIEF.md
# Flash query mode probe sequencer

This block brings a parallel NOR flash bank into its query mode. After a start pulse it runs up to five unlock recipes, one after the other. Each recipe opens with a reset write and ends with the query command. Three signature reads then decide whether the recipe worked. If one did, the block can read a span of the device's extended parameter table and stream each byte out. In every case it then returns the bank to read-array mode. At the end it raises a one-cycle done pulse, with a found flag that tells whether the signature was seen.

All accesses leave through a single request port with a valid/ready handshake, one word per access. A small command formatter turns each (word offset, command byte) pair into a bus address and a bus word. The address is the offset multiplied by the bytes of one device times the number of interleaved devices. The bus word carries the command byte in the low byte of every device lane.

States: `S_IDLE` waits for start. `S_UNLOCK` issues the write steps of the current recipe. `S_SIG` makes the signature reads. `S_TABLE` reads table bytes. `S_EXIT` issues the restore writes. `S_DONE` pulses done for one cycle.

Transitions:
- `S_IDLE` goes to `S_UNLOCK` on start.
- `S_UNLOCK` goes to `S_SIG` after the recipe's last write.
- `S_SIG` goes to `S_UNLOCK` on a mismatch with recipes left.
- `S_SIG` goes to `S_EXIT` on a mismatch after recipe five.
- `S_SIG` goes to `S_TABLE` on a full match with a table to read.
- `S_SIG` goes to `S_EXIT` on a full match with no table.
- `S_TABLE` goes to `S_EXIT` after the last byte.
- `S_EXIT` goes to `S_DONE` after the last restore write.
- `S_DONE` goes to `S_IDLE`.

Top module: `qry_probe_seq`

## Requirements
- R1: After reset, and until start, bus_valid, done, found and tbl_valid are all low.
- R2: Every request address equals the word offset times LANES*DEV_BYTES. A write word holds the command byte in bits [7:0] of each DEV_BYTES-wide lane, and all other bits are zero.
- R3: Recipes run in this order. Every recipe opens with 0xF0 at offset 0.
  - Recipe 1: 0x98 at 0x55.
  - Recipe 2: 0xFF at 0, then 0x98 at 0x55.
  - Recipe 3: 0x98 at 0x555.
  - Recipe 4: 0xAA at 0x5555, 0x55 at 0x2AAA, 0x98 at 0x5555.
  - Recipe 5: 0xAA at 0x555, 0x55 at 0x2AA, 0x98 at 0x555.
- R4: After each recipe the block reads offsets 0x10, 0x11 and 0x12 in turn. It compares each word with the formatted 'Q' (0x51), 'R' (0x52) and 'Y' (0x59). The first mismatching read ends that recipe, and the next recipe starts. Three matches stop the search.
- R5: When recipe 5 also fails, the block reads no table, performs the restore writes, and pulses done with found low.
- R6: On success with a nonzero table start and nonzero length, the block reads offsets start through start+len-1 in ascending order. One cycle after each accepted read, tbl_valid pulses with tbl_byte equal to bus_rdata[7:0].
- R7: A table start of zero or a length of zero skips the table reads entirely.
- R8: The restore writes are 0xF0 at offset 0, then 0xFF at offset 0. If quirk_reset was high at start, a further 0xF0 at offset 0 follows. Done rises in the cycle after the last restore write is accepted.
- R9: A request holds bus_valid, bus_write, bus_addr and bus_wdata steady until bus_ready. Each accepted handshake is one access.
- R10: Done lasts exactly one cycle. Found is high only together with done. A start pulse while a probe is running has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch pulse, used in S_IDLE only |
| quirk_reset | input | 1 | Adds a final reset write on exit; latched at start |
| tbl_start | input | 16 | Table start word offset, zero means no table; latched at start |
| tbl_len | input | LEN_W | Number of table bytes; latched at start |
| bus_valid | output | 1 | Request valid |
| bus_write | output | 1 | 1 = write, 0 = read |
| bus_addr | output | ADDR_W | Byte address of the request |
| bus_wdata | output | 8*LANES*DEV_BYTES | Write word, zero for reads |
| bus_ready | input | 1 | Request accepted this cycle; read data valid with it |
| bus_rdata | input | 8*LANES*DEV_BYTES | Read word |
| tbl_valid | output | 1 | Table byte strobe |
| tbl_byte | output | 8 | Table byte |
| done | output | 1 | One-cycle completion pulse |
| found | output | 1 | Signature seen, valid with done |

## Verification
Two things happen in the same cycle at the end of a table read. The strobe for the last table byte comes out while the first restore write (0xF0 at offset 0) is already on the request port. The bench provokes this by running table reads under both zero-wait and multi-cycle-wait bus responses. In each case it checks that tbl_valid and a pending 0xF0 write were seen in the same sampled cycle. It also checks that the byte stream and the write log still match the expected sequence exactly.

// File: rtl/qps_pkg.sv
package qps_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_UNLOCK,
        S_SIG,
        S_TABLE,
        S_EXIT,
        S_DONE
    } qps_state_t;

    localparam int unsigned NUM_RECIPES = 5;

    localparam logic [7:0] CMD_RESET  = 8'hF0;
    localparam logic [7:0] CMD_ARRAY  = 8'hFF;
    localparam logic [7:0] CMD_QUERY  = 8'h98;
    localparam logic [7:0] CMD_KEY_A  = 8'hAA;
    localparam logic [7:0] CMD_KEY_B  = 8'h55;

    localparam logic [7:0] SIG_CHAR_0 = 8'h51;
    localparam logic [7:0] SIG_CHAR_1 = 8'h52;
    localparam logic [7:0] SIG_CHAR_2 = 8'h59;

    localparam logic [15:0] SIG_BASE_OFS = 16'h0010;

endpackage

// File: rtl/qps_step_rom.sv
module qps_step_rom
    import qps_pkg::*;
(
    input  logic        exit_sel,
    input  logic [2:0]  recipe,
    input  logic [1:0]  step,
    input  logic        quirk,
    output logic [7:0]  cmd,
    output logic [15:0] ofs,
    output logic        last
);

    always_comb begin
        cmd  = CMD_RESET;
        ofs  = 16'h0000;
        last = 1'b0;
        if (exit_sel) begin
            unique case (step)
                2'd0:    begin cmd = CMD_RESET; end
                2'd1:    begin cmd = CMD_ARRAY; last = ~quirk; end
                default: begin cmd = CMD_RESET; last = 1'b1; end
            endcase
        end else if (step != 2'd0) begin
            unique case (recipe)
                3'd0: begin cmd = CMD_QUERY; ofs = 16'h0055; last = 1'b1; end
                3'd1: begin
                    if (step == 2'd1) begin
                        cmd = CMD_ARRAY;
                    end else begin
                        cmd = CMD_QUERY; ofs = 16'h0055; last = 1'b1;
                    end
                end
                3'd2: begin cmd = CMD_QUERY; ofs = 16'h0555; last = 1'b1; end
                3'd3: begin
                    unique case (step)
                        2'd1:    begin cmd = CMD_KEY_A; ofs = 16'h5555; end
                        2'd2:    begin cmd = CMD_KEY_B; ofs = 16'h2AAA; end
                        default: begin cmd = CMD_QUERY; ofs = 16'h5555; last = 1'b1; end
                    endcase
                end
                default: begin
                    unique case (step)
                        2'd1:    begin cmd = CMD_KEY_A; ofs = 16'h0555; end
                        2'd2:    begin cmd = CMD_KEY_B; ofs = 16'h02AA; end
                        default: begin cmd = CMD_QUERY; ofs = 16'h0555; last = 1'b1; end
                    endcase
                end
            endcase
        end
    end

endmodule

// File: rtl/qps_cmd_fmt.sv
module qps_cmd_fmt #(
    parameter int unsigned ADDR_W    = 24,
    parameter int unsigned LANES     = 1,
    parameter int unsigned DEV_BYTES = 2,
    localparam int unsigned SCALE    = LANES * DEV_BYTES,
    localparam int unsigned DEV_W    = DEV_BYTES * 8,
    localparam int unsigned DATA_W   = SCALE * 8
) (
    input  logic [15:0]       ofs,
    input  logic [7:0]        cmd,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] data
);

    assign addr = ADDR_W'(32'(ofs) * SCALE);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign data[g*DEV_W +: DEV_W] = DEV_W'(cmd);
    end

endmodule

// File: rtl/qry_probe_seq.sv
module qry_probe_seq
    import qps_pkg::*;
#(
    parameter int unsigned ADDR_W    = 24,
    parameter int unsigned LANES     = 1,
    parameter int unsigned DEV_BYTES = 2,
    parameter int unsigned LEN_W     = 8,
    localparam int unsigned DATA_W   = LANES * DEV_BYTES * 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              quirk_reset,
    input  logic [15:0]       tbl_start,
    input  logic [LEN_W-1:0]  tbl_len,
    output logic              bus_valid,
    output logic              bus_write,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_ready,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              tbl_valid,
    output logic [7:0]        tbl_byte,
    output logic              done,
    output logic              found
);

    localparam logic [2:0] LAST_RECIPE = 3'(NUM_RECIPES - 1);

    qps_state_t        state;
    logic [2:0]        recipe;
    logic [1:0]        step;
    logic [1:0]        sig_idx;
    logic [15:0]       tbl_ofs;
    logic [LEN_W-1:0]  tbl_left;
    logic [15:0]       tbl_start_q;
    logic [LEN_W-1:0]  tbl_len_q;
    logic              quirk_q;
    logic              found_q;
    logic              tbl_valid_q;
    logic [7:0]        tbl_byte_q;

    logic [7:0]        rom_cmd;
    logic [15:0]       rom_ofs;
    logic              rom_last;
    logic [15:0]       fmt_ofs;
    logic [7:0]        fmt_cmd;
    logic [ADDR_W-1:0] fmt_addr;
    logic [DATA_W-1:0] fmt_data;
    logic              sig_match;
    logic              want_table;

    qps_step_rom u_rom (
        .exit_sel (state == S_EXIT),
        .recipe   (recipe),
        .step     (step),
        .quirk    (quirk_q),
        .cmd      (rom_cmd),
        .ofs      (rom_ofs),
        .last     (rom_last)
    );

    always_comb begin
        unique case (state)
            S_SIG: begin
                fmt_ofs = SIG_BASE_OFS + 16'(sig_idx);
                fmt_cmd = (sig_idx == 2'd0) ? SIG_CHAR_0 :
                          (sig_idx == 2'd1) ? SIG_CHAR_1 : SIG_CHAR_2;
            end
            S_TABLE: begin
                fmt_ofs = tbl_ofs;
                fmt_cmd = 8'h00;
            end
            default: begin
                fmt_ofs = rom_ofs;
                fmt_cmd = rom_cmd;
            end
        endcase
    end

    qps_cmd_fmt #(
        .ADDR_W    (ADDR_W),
        .LANES     (LANES),
        .DEV_BYTES (DEV_BYTES)
    ) u_fmt (
        .ofs  (fmt_ofs),
        .cmd  (fmt_cmd),
        .addr (fmt_addr),
        .data (fmt_data)
    );

    assign sig_match  = (bus_rdata == fmt_data);
    assign want_table = (tbl_start_q != 16'h0000) && (tbl_len_q != '0);

    // state register and sequencing counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state       <= S_IDLE;
            recipe      <= '0;
            step        <= '0;
            sig_idx     <= '0;
            tbl_ofs     <= '0;
            tbl_left    <= '0;
            tbl_start_q <= '0;
            tbl_len_q   <= '0;
            quirk_q     <= 1'b0;
            found_q     <= 1'b0;
            tbl_valid_q <= 1'b0;
            tbl_byte_q  <= '0;
        end else begin
            tbl_valid_q <= 1'b0;
            unique case (state)
                S_IDLE: begin
                    if (start) begin
                        tbl_start_q <= tbl_start;
                        tbl_len_q   <= tbl_len;
                        quirk_q     <= quirk_reset;
                        found_q     <= 1'b0;
                        recipe      <= '0;
                        step        <= '0;
                        state       <= S_UNLOCK;
                    end
                end
                S_UNLOCK: begin
                    if (bus_ready) begin
                        if (rom_last) begin
                            sig_idx <= '0;
                            state   <= S_SIG;
                        end else begin
                            step <= step + 2'd1;
                        end
                    end
                end
                S_SIG: begin
                    if (bus_ready) begin
                        if (!sig_match) begin
                            step <= '0;
                            if (recipe == LAST_RECIPE) begin
                                state <= S_EXIT;
                            end else begin
                                recipe <= recipe + 3'd1;
                                state  <= S_UNLOCK;
                            end
                        end else if (sig_idx == 2'd2) begin
                            found_q  <= 1'b1;
                            step     <= '0;
                            tbl_ofs  <= tbl_start_q;
                            tbl_left <= tbl_len_q;
                            state    <= want_table ? S_TABLE : S_EXIT;
                        end else begin
                            sig_idx <= sig_idx + 2'd1;
                        end
                    end
                end
                S_TABLE: begin
                    if (bus_ready) begin
                        tbl_valid_q <= 1'b1;
                        tbl_byte_q  <= bus_rdata[7:0];
                        tbl_ofs     <= tbl_ofs + 16'd1;
                        tbl_left    <= tbl_left - 1'b1;
                        if (tbl_left == LEN_W'(1)) begin
                            step  <= '0;
                            state <= S_EXIT;
                        end
                    end
                end
                S_EXIT: begin
                    if (bus_ready) begin
                        if (rom_last) state <= S_DONE;
                        else          step  <= step + 2'd1;
                    end
                end
                S_DONE: state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        bus_valid = 1'b0;
        bus_write = 1'b0;
        done      = 1'b0;
        unique case (state)
            S_UNLOCK, S_EXIT: begin bus_valid = 1'b1; bus_write = 1'b1; end
            S_SIG, S_TABLE:   bus_valid = 1'b1;
            S_DONE:           done      = 1'b1;
            default: ;
        endcase
        bus_addr  = fmt_addr;
        bus_wdata = bus_write ? fmt_data : '0;
        found     = done & found_q;
        tbl_valid = tbl_valid_q;
        tbl_byte  = tbl_byte_q;
    end

endmodule

// File: rtl/qry_probe_seq_chk.sv
module qry_probe_seq_chk #(
    parameter int unsigned ADDR_W = 24,
    parameter int unsigned DATA_W = 16,
    parameter int unsigned SCALE  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_valid,
    input logic              bus_ready,
    input logic              bus_write,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              done,
    input logic              found,
    input logic              tbl_valid
);

    p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid && !bus_ready |=> bus_valid && $stable(bus_addr) &&
                                    $stable(bus_wdata) && $stable(bus_write));

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_found_with_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        found |-> done);

    p_quiet_at_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !bus_valid && !tbl_valid);

    p_done_after_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(bus_valid && bus_write && bus_ready));

    p_addr_scaled_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid |-> (32'(bus_addr) % SCALE) == 0);

endmodule

bind qry_probe_seq qry_probe_seq_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .SCALE  (LANES * DEV_BYTES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_valid (bus_valid),
    .bus_ready (bus_ready),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .done      (done),
    .found     (found),
    .tbl_valid (tbl_valid)
);

// File: tb/qry_probe_seq_tb.sv
module qry_probe_seq_tb;

    localparam int ADDR_W = 24;
    localparam int LANES  = 2;
    localparam int DEVB   = 2;
    localparam int SCALE  = LANES * DEVB;
    localparam int DW     = SCALE * 8;
    localparam int MAXLOG = 128;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          quirk_reset = 1'b0;
    logic [15:0]   tbl_start = '0;
    logic [7:0]    tbl_len = '0;
    logic          bus_valid, bus_write;
    logic [ADDR_W-1:0] bus_addr;
    logic [DW-1:0] bus_wdata;
    logic          bus_ready = 1'b0;
    logic [DW-1:0] bus_rdata = '0;
    logic          tbl_valid, done, found;
    logic [7:0]    tbl_byte;

    always #4 clk = ~clk;

    qry_probe_seq #(
        .ADDR_W(ADDR_W), .LANES(LANES), .DEV_BYTES(DEVB), .LEN_W(8)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .quirk_reset(quirk_reset),
        .tbl_start(tbl_start), .tbl_len(tbl_len),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_ready(bus_ready), .bus_rdata(bus_rdata),
        .tbl_valid(tbl_valid), .tbl_byte(tbl_byte), .done(done), .found(found)
    );

    int nchk = 0;
    int nerr = 0;

    // flash model and observation state
    int  lat = 0, wait_cnt = 0, qcnt = 0, target = 0, bad_att = 0;
    bit  qmode = 0, corrupt = 0, pend = 0, coinc = 0;
    int  hold_err = 0, done_cnt = 0, found_seen = 0, nlog = 0, nrx = 0, nexp = 0;
    logic [ADDR_W-1:0] p_addr;
    logic [DW-1:0]     p_wdata;
    logic              p_write;
    logic              log_wr   [MAXLOG];
    logic [ADDR_W-1:0] log_addr [MAXLOG];
    logic [DW-1:0]     log_data [MAXLOG];
    logic              exp_wr   [MAXLOG];
    logic [ADDR_W-1:0] exp_addr [MAXLOG];
    logic [DW-1:0]     exp_data [MAXLOG];
    logic [7:0]        rx_tbl   [64];

    function automatic logic [DW-1:0] rep(input logic [7:0] c);
        logic [DW-1:0] r = '0;
        for (int i = 0; i < LANES; i++) r[i*DEVB*8 +: 8] = c;
        return r;
    endfunction

    always @(negedge clk) begin
        if (rst_n) begin
            if (tbl_valid && nrx < 64) begin rx_tbl[nrx] = tbl_byte; nrx++; end
            if (tbl_valid && bus_valid && bus_write && bus_wdata == rep(8'hF0)) coinc = 1;
            if (done) begin done_cnt++; found_seen = int'(found); end
            if (pend && !(bus_valid && bus_addr == p_addr && bus_wdata == p_wdata &&
                          bus_write == p_write)) hold_err++;
            if (bus_valid && wait_cnt >= lat) begin
                int off;
                bus_ready = 1'b1;
                wait_cnt = 0;
                pend = 0;
                off = int'(bus_addr) / SCALE;
                if (nlog < MAXLOG) begin
                    log_wr[nlog] = bus_write; log_addr[nlog] = bus_addr;
                    log_data[nlog] = bus_wdata; nlog++;
                end
                if (bus_write) begin
                    if (bus_wdata[7:0] == 8'h98) begin
                        qcnt++;
                        qmode = (qcnt == target) || (qcnt == bad_att);
                        corrupt = (qcnt == bad_att);
                    end else if (bus_wdata[7:0] == 8'hF0 || bus_wdata[7:0] == 8'hFF) begin
                        qmode = 0;
                    end
                    bus_rdata = '1;
                end else if (qmode && off == 16'h10) bus_rdata = rep(8'h51);
                else if (qmode && off == 16'h11) bus_rdata = corrupt ? rep(8'h00) : rep(8'h52);
                else if (qmode && off == 16'h12) bus_rdata = rep(8'h59);
                else if (qmode && off >= 16'h20) bus_rdata = rep(8'(off) ^ 8'h5A);
                else bus_rdata = '1;
            end else begin
                bus_ready = 1'b0;
                if (bus_valid) begin
                    wait_cnt++;
                    pend = 1; p_addr = bus_addr; p_wdata = bus_wdata; p_write = bus_write;
                end else pend = 0;
            end
        end
    end

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            nerr++; nchk++;
            $display("FAIL watchdog R10: actual=%0d expected=%0d", cyc, 100000);
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic push(input bit w, input int ofs, input logic [7:0] c);
        exp_wr[nexp] = w;
        exp_addr[nexp] = ADDR_W'(ofs * SCALE);
        exp_data[nexp] = w ? rep(c) : '0;
        nexp++;
    endtask

    task automatic push_recipe(input int a);
        push(1, 0, 8'hF0);
        case (a)
            1: push(1, 'h55, 8'h98);
            2: begin push(1, 0, 8'hFF); push(1, 'h55, 8'h98); end
            3: push(1, 'h555, 8'h98);
            4: begin push(1, 'h5555, 8'hAA); push(1, 'h2AAA, 8'h55); push(1, 'h5555, 8'h98); end
            default: begin push(1, 'h555, 8'hAA); push(1, 'h2AA, 8'h55); push(1, 'h555, 8'h98); end
        endcase
    endtask

    task automatic run_case(input string name, input int tgt, input int bad, input bit qk,
                            input int ofs, input int len, input int latency, input bit poke);
        bit hit = 0;
        int mism = 0;
        int first_bad = -1;
        int rx_bad = 0;
        // expected sequence (R3, R4, R6, R7, R8)
        nexp = 0;
        for (int a = 1; a <= 5 && !hit; a++) begin
            push_recipe(a);
            push(0, 'h10, 8'h00);
            if (a == tgt) begin push(0, 'h11, 8'h00); push(0, 'h12, 8'h00); hit = 1; end
            else if (a == bad) push(0, 'h11, 8'h00);
        end
        if (hit && ofs != 0 && len != 0)
            for (int i = 0; i < len; i++) push(0, ofs + i, 8'h00);
        push(1, 0, 8'hF0);
        push(1, 0, 8'hFF);
        if (qk) push(1, 0, 8'hF0);
        // arm model
        @(negedge clk); #1;
        lat = latency; wait_cnt = 0; qcnt = 0; target = tgt; bad_att = bad;
        qmode = 0; corrupt = 0; pend = 0; coinc = 0; hold_err = 0;
        done_cnt = 0; found_seen = -1; nlog = 0; nrx = 0;
        quirk_reset = qk; tbl_start = 16'(ofs); tbl_len = 8'(len);
        start = 1'b1;
        @(negedge clk); #1;
        start = 1'b0; quirk_reset = 1'b0; tbl_start = '0; tbl_len = '0;
        for (int i = 0; i < 3000 && done_cnt == 0; i++) begin
            if (poke && i == 6) begin start = 1'b1; quirk_reset = ~qk; end
            if (poke && i == 7) begin start = 1'b0; quirk_reset = 1'b0; end
            @(negedge clk); #1;
        end
        for (int i = 0; i < 4; i++) begin @(negedge clk); #1; end
        $display("case %s", name);
        chk(done_cnt == 1, "R10 single done pulse", done_cnt, 1);
        chk(found_seen == int'(hit), hit ? "R4 found flag" : "R5 found flag",
            found_seen, int'(hit));
        chk(nlog == nexp, "R3 access count", nlog, nexp);
        for (int i = 0; i < nexp && i < nlog; i++) begin
            if (log_wr[i] != exp_wr[i] || log_addr[i] != exp_addr[i] ||
                (exp_wr[i] && log_data[i] != exp_data[i])) begin
                mism++;
                if (first_bad < 0) first_bad = i;
            end
        end
        chk(mism == 0, "R2 R3 access content", first_bad, -1);
        if (hit && ofs != 0 && len != 0) begin
            chk(nrx == len, "R6 table byte count", nrx, len);
            for (int i = 0; i < nrx && i < len; i++)
                if (rx_tbl[i] != (8'(ofs + i) ^ 8'h5A)) rx_bad++;
            chk(rx_bad == 0, "R6 table byte values", rx_bad, 0);
            chk(coinc, "R6 last byte beside first exit write", int'(coinc), 1);
        end else begin
            chk(nrx == 0, hit ? "R7 no table bytes" : "R5 no table bytes", nrx, 0);
        end
        if (latency > 0) chk(hold_err == 0, "R9 request held", hold_err, 0);
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        #1;
        chk(!bus_valid && !done && !found && !tbl_valid, "R1 idle while in reset",
            int'({bus_valid, done, found, tbl_valid}), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        #1;
        chk(!bus_valid && !done && !found && !tbl_valid, "R1 idle after reset",
            int'({bus_valid, done, found, tbl_valid}), 0);
    endtask

    initial begin
        t_reset();
        run_case("first recipe with table", 1, 0, 0, 'h40, 4, 0, 0);
        run_case("third recipe, zero start", 3, 0, 0, 0, 5, 1, 0);
        run_case("fifth recipe, quirk, slow bus", 5, 0, 1, 'h31, 3, 2, 0);
        run_case("no recipe works", 0, 0, 0, 'h40, 2, 0, 0);
        run_case("R4 early mismatch then recipe 4, start poked", 4, 1, 0, 'h20, 1, 1, 1);
        run_case("R7 second recipe, zero length", 2, 0, 1, 'h50, 0, 0, 0);
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule